// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Array

This block multiplies a stream of signed 8-bit input vectors by a square tile of signed 8-bit weights that stays in place. It holds N×N multiply-accumulate cells. One whole input vector is accepted per cycle. A triangular delay stage staggers the elements of the vector so that element k reaches the left edge of the array k cycles after element 0. Input elements travel right by one cell per cycle. Partial sums travel down the columns. The bottom row produces one column sum per column, and a mirrored delay stage realigns those sums so that the whole result vector leaves on a single cycle, marked by a valid pulse.

Each cell holds two weight registers, one active and one idle. A tile for the next layer is pushed in one row per cycle on a separate load port. Each row travels down the columns until it reaches its own row, where it is written into the idle register. Computation continues during the load. A vector marked as a switch changes the active register in every cell at the moment that vector's element passes through the cell. Vectors ahead of it finish with the old tile, and the switch vector and everything after it use the new one.

Top module: `ws_systolic_array`

## Requirements
- R1: Each input vector accepted with `in_valid` high produces exactly one result. The result appears on `out_vec` with `out_valid` high after the (2N-1)-th rising edge following the sampling edge, with all N columns on that same cycle. Cycles without a valid input produce no `out_valid` pulse.
- R2: Input element i is `in_vec[8i+7:8i]`, two's complement. Column j of the result is `out_vec[32j+31:32j]`. Its value is the sum over i of x[i]·W[i][j], as a 32-bit two's-complement number that wraps modulo 2^32. Extreme values such as -128·-128 on every row give exact sums.
- R3: Vectors presented on consecutive cycles give results that are independent of each other, with no mixing of elements between neighbouring vectors.
- R4: Reset clears both weight registers of every cell and makes register 0 active. Reset also clears all pipeline state, so `out_valid` and `out_vec` are zero. Until the first switch, every result is zero.
- R5: A vector presented with `in_valid` and `in_switch` both high is computed with the newly loaded tile, and so is every vector after it. A vector presented one cycle earlier still uses the previous tile.
- R6: A cycle with `ld_valid` high is a load beat carrying one weight row on `ld_row`, with element j at bits [8j+7:8j] and destined for column j. Beat number k after reset, counted modulo N, writes row k. The row goes into each cell's idle register and has no effect on any result until the next switch.
- R7: A tile load may start N cycles after the sampling edge of the last switch vector. The next switch may follow the final load beat by N cycles. Under these spacing rules, vectors streaming every cycle during the load all keep the active tile, and a write never meets a cell on the cycle that cell changes register.
- R8: `in_switch` sampled while `in_valid` is low is ignored: the active tile stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_switch | input | 1 | Marks this vector as the first to use the next tile |
| in_vec | input | N*8 | Input vector, element i at bits [8i+7:8i] |
| ld_valid | input | 1 | Load beat present this cycle |
| ld_row | input | N*8 | One weight row, element j for column j |
| out_valid | output | 1 | Result vector present this cycle |
| out_vec | output | N*32 | Column sums, column j at bits [32j+31:32j] |

## Verification
The array is first driven with vectors before any switch, which must all give zero and so show that the reset tile is empty. It is then driven with back-to-back random vectors, which expose any skew misalignment as mixed elements. Vectors with bubbles between them separate the timing of the valid flag from the data. Tiles of all -128 weights, combined with inputs of -128 and +127, probe sign handling and the widening of the partial sums.

Tile changes are tested at their edges. A plain vector is followed directly by a switch vector. A tile is loaded while vectors stream every cycle. A switch request is given without a valid vector. Each of these cases distinguishes a correct wavefront from one that flips too early, too late or spuriously.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int DATA_W = 8;
    localparam int ACC_W  = 32;
    localparam int PROD_W = 2 * DATA_W;

    // One element travelling right along a row, tagged with its vector's flags.
    typedef struct packed {
        logic              vld;
        logic              sw;
        logic [DATA_W-1:0] val;
    } lane_t;

    // Width of the partial sum leaving a given row: the product width plus one bit
    // per adder above, never wider than the accumulator.
    function automatic int psum_w(int row);
        return (PROD_W + row > ACC_W) ? ACC_W : PROD_W + row;
    endfunction

endpackage

// File: rtl/sa_skew.sv
module sa_skew
    import sa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i [N],
    output lane_t lane_o [N]
);

    for (genvar k = 0; k < N; k++) begin : g_lane
        if (k == 0) begin : g_direct
            assign lane_o[0] = lane_i[0];
        end else begin : g_delay
            lane_t dq [k];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < k; j++) dq[j] <= '0;
                end else begin
                    dq[0] <= lane_i[k];
                    for (int j = 1; j < k; j++) dq[j] <= dq[j-1];
                end
            end

            assign lane_o[k] = dq[k-1];

            // R3: each lane trails its upper neighbour by exactly one cycle.
            a_r3_skew_step: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (lane_o[k].vld == $past(lane_o[k-1].vld)) &&
                                (lane_o[k].sw  == $past(lane_o[k-1].sw)));
        end
    end

endmodule

// File: rtl/sa_cell.sv
module sa_cell
    import sa_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lane_t                         lane_i,
    output lane_t                         lane_o,
    input  logic signed [psum_w((ROW > 0) ? ROW - 1 : 0)-1:0] psum_i,
    output logic signed [psum_w(ROW)-1:0] psum_o,
    input  logic                          ld_we,
    input  logic [DATA_W-1:0]             ld_w
);

    localparam int PW = psum_w(ROW);

    logic [DATA_W-1:0]        wbuf [2];
    logic                     sel;
    logic                     flip;
    logic signed [DATA_W-1:0] w_eff;
    logic signed [PROD_W-1:0] prod;

    // A switch element already uses the idle register on the cycle it arrives.
    assign flip  = lane_i.vld & lane_i.sw;
    assign w_eff = wbuf[sel ^ flip];
    assign prod  = $signed(lane_i.val) * w_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf[0] <= '0;
            wbuf[1] <= '0;
            sel     <= 1'b0;
            lane_o  <= '0;
            psum_o  <= '0;
        end else begin
            lane_o <= lane_i;
            psum_o <= PW'(psum_i) + PW'(prod);
            if (flip)  sel       <= ~sel;
            if (ld_we) wbuf[~sel] <= ld_w;
        end
    end

    // R7: a row write never lands on the cycle this cell changes register.
    a_r7_no_load_on_flip: assert property (@(posedge clk) disable iff (rst)
        !(flip && ld_we));

    // R5: the active register changes only behind a valid switch element.
    a_r5_flip_needs_switch: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> $past(lane_i.vld && lane_i.sw));

endmodule

// File: rtl/sa_deskew.sv
module sa_deskew
    import sa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] col_i [N],
    input  logic [N-1:0]     vld_i,
    output logic [N*ACC_W-1:0] vec_o,
    output logic [N-1:0]     vld_o
);

    for (genvar c = 0; c < N; c++) begin : g_col
        localparam int D = N - c;
        logic [ACC_W:0] dq [D];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < D; j++) dq[j] <= '0;
            end else begin
                dq[0] <= {vld_i[c], col_i[c]};
                for (int j = 1; j < D; j++) dq[j] <= dq[j-1];
            end
        end

        assign {vld_o[c], vec_o[c*ACC_W +: ACC_W]} = dq[D-1];
    end

    // R1: every column of a result leaves on the same cycle.
    a_r1_cols_aligned: assert property (@(posedge clk) disable iff (rst)
        (vld_o == '0) || (vld_o == '1));

endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array
    import sa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_switch,
    input  logic [N*DATA_W-1:0]   in_vec,
    input  logic                  ld_valid,
    input  logic [N*DATA_W-1:0]   ld_row,
    output logic                  out_valid,
    output logic [N*ACC_W-1:0]    out_vec
);

    localparam int TW = (N > 1) ? $clog2(N) : 1;

    lane_t          in_l [N];
    lane_t          sk_l [N];
    logic [TW-1:0]  ld_cnt;
    logic [ACC_W-1:0] col_w [N];
    logic [N-1:0]   col_v;
    logic [N-1:0]   vld_o;

    for (genvar i = 0; i < N; i++) begin : g_in
        assign in_l[i] = '{vld: in_valid,
                           sw:  in_valid & in_switch,
                           val: in_vec[i*DATA_W +: DATA_W]};
    end

    sa_skew #(.N(N)) u_skew (
        .clk    (clk),
        .rst    (rst),
        .lane_i (in_l),
        .lane_o (sk_l)
    );

    // Beat k (modulo N) is tagged for row k.
    always_ff @(posedge clk) begin
        if (rst)           ld_cnt <= '0;
        else if (ld_valid) ld_cnt <= (ld_cnt == TW'(N - 1)) ? '0 : ld_cnt + 1'b1;
    end

    a_r6_beat_wraps: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_cnt == TW'(N - 1)) |=> (ld_cnt == '0));

    for (genvar r = 0; r < N; r++) begin : g_row
        localparam int PW  = psum_w(r);
        localparam int PWI = psum_w((r > 0) ? r - 1 : 0);

        lane_t                ln  [N+1];
        logic signed [PWI-1:0] pin [N];
        logic signed [PW-1:0]  ps  [N];
        logic                 cv;
        logic [TW-1:0]        ct;
        logic [N*DATA_W-1:0]  cd;

        assign ln[0] = sk_l[r];

        // Weight carrier: rows fall one row per cycle down the columns.
        if (r == 0) begin : g_first
            assign cv = ld_valid;
            assign ct = ld_cnt;
            assign cd = ld_row;
            for (genvar c = 0; c < N; c++) begin : g_z
                assign pin[c] = '0;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    cv <= 1'b0;
                    ct <= '0;
                    cd <= '0;
                end else begin
                    cv <= g_row[r-1].cv;
                    ct <= g_row[r-1].ct;
                    cd <= g_row[r-1].cd;
                end
            end
            for (genvar c = 0; c < N; c++) begin : g_p
                assign pin[c] = g_row[r-1].ps[c];
            end
        end

        for (genvar c = 0; c < N; c++) begin : g_col
            sa_cell #(.ROW(r)) u_cell (
                .clk    (clk),
                .rst    (rst),
                .lane_i (ln[c]),
                .lane_o (ln[c+1]),
                .psum_i (pin[c]),
                .psum_o (ps[c]),
                .ld_we  (cv && (ct == TW'(r))),
                .ld_w   (cd[c*DATA_W +: DATA_W])
            );
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_bot
        assign col_w[c] = ACC_W'(g_row[N-1].ps[c]);
        assign col_v[c] = g_row[N-1].ln[c+1].vld;
    end

    sa_deskew #(.N(N)) u_deskew (
        .clk   (clk),
        .rst   (rst),
        .col_i (col_w),
        .vld_i (col_v),
        .vec_o (out_vec),
        .vld_o (vld_o)
    );

    assign out_valid = &vld_o;

endmodule

// File: tb/ws_systolic_array_tb.sv
module ws_systolic_array_tb;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid, in_switch, ld_valid;
    logic [N*DW-1:0] in_vec, ld_row;
    logic            out_valid;
    logic [N*AW-1:0] out_vec;

    always #2 clk = ~clk;

    ws_systolic_array #(.N(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_switch (in_switch),
        .in_vec    (in_vec),
        .ld_valid  (ld_valid),
        .ld_row    (ld_row),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    typedef struct {
        int              due;
        logic [N*AW-1:0] v;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;
    int   act  [N][N];
    int   pend [N][N];
    int   ld_k = 0;
    bit   done = 0;
    bit   want;

    always @(posedge clk) cyc <= cyc + 1;

    // Compare against the behavioural model on every cycle.
    always @(negedge clk) begin
        if (!rst && !done) begin
            while (q.size() > 0 && q[0].due < cyc) begin
                errors++;
                $display("FAIL R1 result lost: due %0d now %0d (got none, expected one)", q[0].due, cyc);
                void'(q.pop_front());
            end
            want = (q.size() > 0) && (q[0].due == cyc);
            checks++;
            if (out_valid !== want) begin
                errors++;
                $display("FAIL R1 out_valid at cycle %0d: got %b expected %b", cyc, out_valid, want);
            end
            if (want) begin
                checks++;
                if (out_vec !== q[0].v) begin
                    errors++;
                    $display("FAIL %s out_vec at cycle %0d: got %h expected %h", q[0].tag, cyc, out_vec, q[0].v);
                end
                void'(q.pop_front());
            end
        end
    end

    function automatic logic [N*DW-1:0] rnd_vec();
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [N*DW-1:0] fill(logic [DW-1:0] b);
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = b;
        return v;
    endfunction

    task automatic drive(bit v, bit sw, logic [N*DW-1:0] x, bit lv, logic [N*DW-1:0] lr, string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = v;
        in_switch = sw;
        in_vec    = x;
        ld_valid  = lv;
        ld_row    = lr;
        if (v) begin
            if (sw) act = pend;
            for (int j = 0; j < N; j++) begin
                int s;
                s = 0;
                for (int i = 0; i < N; i++)
                    s += int'($signed(x[i*DW +: DW])) * act[i][j];
                e.v[j*AW +: AW] = s;
            end
            e.due = cyc + 2 * N;
            e.tag = tag;
            q.push_back(e);
        end
        if (lv) begin
            for (int j = 0; j < N; j++) pend[ld_k][j] = int'($signed(lr[j*DW +: DW]));
            ld_k = (ld_k + 1) % N;
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drive(0, 0, '0, 0, '0, "");
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                act[i][j]  = 0;
                pend[i][j] = 0;
            end
        rst = 1'b1;
        in_valid = 0; in_switch = 0; ld_valid = 0;
        in_vec = '0; ld_row = '0;
        repeat (5) @(negedge clk);
        // R4: reset state of the outputs
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R4 reset outputs: got %b/%h expected 0/0", out_valid, out_vec);
        end
        rst = 1'b0;

        // R4: no switch yet, empty tile
        for (int k = 0; k < 3; k++) drive(1, 0, rnd_vec(), 0, '0, "R4");
        // R6: load tile A while vectors stream, no effect before the switch
        for (int k = 0; k < N; k++) drive(1, 0, rnd_vec(), 1, rnd_vec(), "R6");
        idle(N);
        // R5: switch vector, then R3: back-to-back vectors
        drive(1, 1, rnd_vec(), 0, '0, "R5");
        for (int k = 0; k < 6; k++) drive(1, 0, rnd_vec(), 0, '0, "R3");
        // R1: bubbles between vectors
        for (int k = 0; k < 8; k++) drive(k % 3 != 1, 0, rnd_vec(), 0, '0, "R1");
        idle(N);
        // R8: load B, then a switch request without a valid vector
        for (int k = 0; k < N; k++) drive(0, 0, '0, 1, rnd_vec(), "");
        idle(N);
        drive(0, 1, rnd_vec(), 0, '0, "");
        for (int k = 0; k < 3; k++) drive(1, 0, rnd_vec(), 0, '0, "R8");
        // R5: old tile right before the switch vector, new tile from it on
        drive(1, 0, rnd_vec(), 0, '0, "R5");
        drive(1, 1, rnd_vec(), 0, '0, "R5");
        drive(1, 0, rnd_vec(), 0, '0, "R5");
        idle(N);
        // R7: load an all -128 tile while vectors stream every cycle
        for (int k = 0; k < N; k++) drive(1, 0, rnd_vec(), 1, fill(8'h80), "R7");
        for (int k = 0; k < N; k++) drive(1, 0, rnd_vec(), 0, '0, "R7");
        idle(N);
        // R2: extreme operands
        drive(1, 1, fill(8'h80), 0, '0, "R2");
        drive(1, 0, fill(8'h7F), 0, '0, "R2");
        drive(1, 0, {8'h80, 8'h7F, 8'h01, 8'hFF}, 0, '0, "R2");
        idle(2 * N + 4);
        // R1: every vector produced its result
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1 pending results at end: got %0d expected 0", q.size());
        end
        finish_run();
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got hang expected completion");
            finish_run();
        end
    end

endmodule